// File: doc/BRIEF.md
# Column control packet decoder

This block sits behind the column control pins of a memory device and turns the packet stream on those pins into decoded command strobes. The five pins arrive already split into two beats per clock, so each clock delivers a 10-bit slice. A packet lasts four clocks, or 40 bits. The first 23 bits carry a column command: a start bit, a device field, a bank, a column and an opcode. The last 17 bits carry a side packet. Its mode bit selects between a pair of bytemasks and an extended operation. The extended operation has its own device field.

The command and the extended operation are matched against the device identifier independently. A matched command gives exactly one of the no-op, write, read, precharge, write-with-precharge and read-with-precharge strobes, and a relax flag may come with it. A command addressed to another device gives a separate "other device" strobe, which a write buffer can use to retire. A matched extended operation gives precharge, calibrate, calibrate-and-sample and relax strobes. Bytemasks are presented whatever the device field says. Carrying out these commands is left to other logic.

Top module: `col_pkt_decoder`

## Requirements
- R1: A packet begins in a clock where `col_in[9]` is 1 and `attn` is 1 and no capture is in progress. The next three clocks complete it. Every output strobe for that packet is high during exactly the one clock that follows the fourth capture edge.
- R2: The packet word is built from the four slices, first slice most significant. Its bits are: [39] start, [38:34] command device, [33:29] bank, [28:22] column, [21:18] opcode, [17] spare, [16] mode, [15:0] side payload. `cmd_bank` and `cmd_col` show the captured fields during the strobe clock and are zero in every other clock.
- R3: When the command device equals `dev_id`, opcode bits [2:0] decode as follows: 000 gives no-op, 001 write, 011 read, 100 precharge, 101 write-with-precharge and 111 read-with-precharge. At most one of these strobes, or `cmd_other`, is high at a time.
- R4: Opcode bit 3 raises `cmd_relax` for a matched command, together with whatever bits [2:0] select.
- R5: The opcode bit patterns x010 and x110 raise none of the six command strobes. No error is flagged for them.
- R6: When the command device differs from `dev_id`, only `cmd_other` is raised among the command strobes. `cmd_relax` stays low.
- R7: Mode 1 raises `mask_vld`. It presents payload [15:8] on `mask_a` and [7:0] on `mask_b`, whatever device the command names. No extended strobe is raised. In mode 0 the masks read zero.
- R8: Mode 0 carries an extended device in [15:11], a bank in [10:6] and an extended opcode in [5:1]. Its strobes need only the extended device to match `dev_id`, whatever the command device is. `x_bank` shows [10:6] in mode 0.
- R9: Extended opcode bits: bit 4 gives precharge. Bits 3:2 equal to 10 give calibrate and 11 give calibrate-and-sample. Bit 1 gives relax. The bits combine, so 10010 gives precharge and relax together. Any code with bit 0 set raises nothing, and 00000 raises nothing.
- R10: A start bit seen while `attn` is 0 starts no packet, so no strobe follows.
- R11: A 1 on `col_in[9]` during clocks two to four of a capture is payload and not a start. A new packet may start in the clock right after the fourth.
- R12: During reset and after it, until a packet completes, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_in | input | 10 | Two beats of the five column pins, earlier beat in [9:5] |
| attn | input | 1 | Device is in the state that accepts column packets |
| dev_id | input | 5 | Device identifier |
| cmd_nop | output | 1 | Matched no-op command |
| cmd_wr | output | 1 | Matched write |
| cmd_rd | output | 1 | Matched read |
| cmd_prec | output | 1 | Matched precharge |
| cmd_wra | output | 1 | Matched write with precharge |
| cmd_rda | output | 1 | Matched read with precharge |
| cmd_relax | output | 1 | Matched command carries relax |
| cmd_other | output | 1 | Framed command addressed to another device |
| cmd_bank | output | 5 | Command bank |
| cmd_col | output | 7 | Command column |
| x_prec | output | 1 | Extended precharge |
| x_cal | output | 1 | Extended calibrate |
| x_calsam | output | 1 | Extended calibrate and sample |
| x_relax | output | 1 | Extended relax |
| x_bank | output | 5 | Extended operation bank |
| mask_vld | output | 1 | Side packet holds bytemasks |
| mask_a | output | 8 | First bytemask |
| mask_b | output | 8 | Second bytemask |

## Verification
The hardest case to reach from the ports is a start bit that shows up inside a packet's payload while the next packet follows with no gap. If that bit were mistaken for a start, the framing would slip and every later strobe would be wrong. The stimulus uses an odd bank, an opcode with bit 1 set and an extended bank with its top bits set, so `col_in[9]` is high in all three continuation clocks. It sends such packets back to back. The scoreboard ties each expected result to the exact clock in which it must appear, so a slipped frame is caught as a wrong or unexpected strobe. Packets sent with `attn` low are also tied to a clock, and there they must show all zeros.

// File: rtl/colpkt_pkg.sv
package colpkt_pkg;

  localparam int DEV_W  = 5;
  localparam int BANK_W = 5;
  localparam int COL_W  = 7;
  localparam int OP_W   = 4;
  localparam int XOP_W  = 5;
  localparam int MASK_W = 8;
  localparam int PKT_LEN = 40;
  localparam int CMD_W  = DEV_W + BANK_W + COL_W + OP_W;   // 21 decoded bits
  localparam int SIDE_W = 1 + 2 * MASK_W;                  // 17 bits

  typedef struct packed {
    logic nop;
    logic wr;
    logic rd;
    logic prec;
    logic wra;
    logic rda;
    logic relax;
    logic other;
  } cmd_strb_t;

  typedef struct packed {
    logic prec;
    logic cal;
    logic calsam;
    logic relax;
  } xop_strb_t;

  // Command opcode: bit 3 adds relax, bits 2:0 select the column action.
  function automatic cmd_strb_t cop_decode(input logic [OP_W-1:0] op,
                                           input logic hit, input logic vld);
    cmd_strb_t s;
    s = '0;
    if (vld) begin
      if (!hit) begin
        s.other = 1'b1;
      end else begin
        s.relax = op[3];
        case (op[2:0])
          3'b000:  s.nop  = 1'b1;
          3'b001:  s.wr   = 1'b1;
          3'b011:  s.rd   = 1'b1;
          3'b100:  s.prec = 1'b1;
          3'b101:  s.wra  = 1'b1;
          3'b111:  s.rda  = 1'b1;
          default: ;
        endcase
      end
    end
    return s;
  endfunction

  // Extended opcode: any code with bit 0 set is reserved; other bits combine.
  function automatic xop_strb_t xop_decode(input logic [XOP_W-1:0] x,
                                           input logic hit, input logic vld);
    xop_strb_t s;
    s = '0;
    if (vld && hit && !x[0]) begin
      s.prec   = x[4];
      s.relax  = x[1];
      s.cal    = x[3] & ~x[2];
      s.calsam = x[3] &  x[2];
    end
    return s;
  endfunction

endpackage

// File: rtl/col_deser.sv
module col_deser #(
  parameter int BUS_W  = 10,
  parameter int CYCLES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BUS_W-1:0]          col_in,
  input  logic                      attn,
  output logic                      start_take,
  output logic                      pkt_vld,
  output logic [BUS_W*CYCLES-1:0]   pkt
);
  localparam int PKT_W = BUS_W * CYCLES;
  localparam int SH_W  = PKT_W - BUS_W;
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic             last_slice;

  assign start_take = !busy && col_in[BUS_W-1] && attn;
  assign last_slice = busy && (cnt == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      pkt     <= '0;
      pkt_vld <= 1'b0;
    end else begin
      pkt_vld <= 1'b0;
      if (start_take) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(1);
        sh   <= SH_W'(col_in);
      end else if (last_slice) begin
        busy    <= 1'b0;
        cnt     <= '0;
        pkt     <= {sh, col_in};
        pkt_vld <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
        sh  <= {sh[SH_W-BUS_W-1:0], col_in};
      end
    end
  end
endmodule

// File: rtl/col_cmd_dec.sv
module col_cmd_dec
  import colpkt_pkg::*;
(
  input  logic                    vld,
  input  logic [CMD_W-1:0]        cmd,
  input  logic [DEV_W-1:0]        dev_id,
  output cmd_strb_t               strb,
  output logic [BANK_W-1:0]       bank,
  output logic [COL_W-1:0]        col
);
  logic [DEV_W-1:0] c_dev;
  logic [OP_W-1:0]  c_op;
  logic             dev_hit;

  assign c_dev   = cmd[CMD_W-1 -: DEV_W];
  assign c_op    = cmd[OP_W-1:0];
  assign dev_hit = (c_dev == dev_id);
  assign strb    = cop_decode(c_op, dev_hit, vld);
  assign bank    = vld ? cmd[OP_W+COL_W +: BANK_W] : '0;
  assign col     = vld ? cmd[OP_W +: COL_W] : '0;
endmodule

// File: rtl/col_side_dec.sv
module col_side_dec
  import colpkt_pkg::*;
(
  input  logic                 vld,
  input  logic [SIDE_W-1:0]    side,
  input  logic [DEV_W-1:0]     dev_id,
  output xop_strb_t            xstrb,
  output logic [BANK_W-1:0]    xbank,
  output logic                 mask_vld,
  output logic [MASK_W-1:0]    mask_a,
  output logic [MASK_W-1:0]    mask_b
);
  logic             mode_mask;
  logic             xop_vld;
  logic [DEV_W-1:0] x_dev;
  logic [XOP_W-1:0] x_op;
  logic             x_hit;

  assign mode_mask = side[SIDE_W-1];
  assign xop_vld   = vld && !mode_mask;
  assign x_dev     = side[2*MASK_W-1 -: DEV_W];
  assign x_op      = side[XOP_W:1];
  assign x_hit     = (x_dev == dev_id);
  assign xstrb     = xop_decode(x_op, x_hit, xop_vld);
  assign xbank     = xop_vld ? side[XOP_W+1 +: BANK_W] : '0;
  assign mask_vld  = vld && mode_mask;
  assign mask_a    = mask_vld ? side[2*MASK_W-1 -: MASK_W] : '0;
  assign mask_b    = mask_vld ? side[MASK_W-1:0] : '0;
endmodule

// File: rtl/col_pkt_decoder.sv
module col_pkt_decoder
  import colpkt_pkg::*;
#(
  parameter int PINS   = 5,
  parameter int BEATS  = 2,
  parameter int CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PINS*BEATS-1:0] col_in,
  input  logic                 attn,
  input  logic [4:0]           dev_id,
  output logic                 cmd_nop,
  output logic                 cmd_wr,
  output logic                 cmd_rd,
  output logic                 cmd_prec,
  output logic                 cmd_wra,
  output logic                 cmd_rda,
  output logic                 cmd_relax,
  output logic                 cmd_other,
  output logic [4:0]           cmd_bank,
  output logic [6:0]           cmd_col,
  output logic                 x_prec,
  output logic                 x_cal,
  output logic                 x_calsam,
  output logic                 x_relax,
  output logic [4:0]           x_bank,
  output logic                 mask_vld,
  output logic [7:0]           mask_a,
  output logic [7:0]           mask_b
);
  localparam int BUS_W = PINS * BEATS;
  localparam int PKT_W = BUS_W * CYCLES;

  logic              start_take;
  logic              pkt_vld;
  logic [PKT_W-1:0]  pkt;
  cmd_strb_t         cstrb;
  xop_strb_t         xstrb;
  logic              unused_frame_bits;

  col_deser #(.BUS_W(BUS_W), .CYCLES(CYCLES)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_in     (col_in),
    .attn       (attn),
    .start_take (start_take),
    .pkt_vld    (pkt_vld),
    .pkt        (pkt)
  );

  // Start bit and command spare bit carry no decoded meaning.
  assign unused_frame_bits = pkt[PKT_LEN-1] ^ pkt[SIDE_W];

  col_cmd_dec u_cmd (
    .vld    (pkt_vld),
    .cmd    (pkt[PKT_LEN-2 -: CMD_W]),
    .dev_id (dev_id),
    .strb   (cstrb),
    .bank   (cmd_bank),
    .col    (cmd_col)
  );

  col_side_dec u_side (
    .vld      (pkt_vld),
    .side     (pkt[SIDE_W-1:0]),
    .dev_id   (dev_id),
    .xstrb    (xstrb),
    .xbank    (x_bank),
    .mask_vld (mask_vld),
    .mask_a   (mask_a),
    .mask_b   (mask_b)
  );

  assign cmd_nop   = cstrb.nop;
  assign cmd_wr    = cstrb.wr;
  assign cmd_rd    = cstrb.rd;
  assign cmd_prec  = cstrb.prec;
  assign cmd_wra   = cstrb.wra;
  assign cmd_rda   = cstrb.rda;
  assign cmd_relax = cstrb.relax;
  assign cmd_other = cstrb.other;
  assign x_prec    = xstrb.prec;
  assign x_cal     = xstrb.cal;
  assign x_calsam  = xstrb.calsam;
  assign x_relax   = xstrb.relax;
endmodule

// File: rtl/col_pkt_decoder_chk.sv
module col_pkt_decoder_chk #(
  parameter int BUS_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] col_in,
  input logic             attn,
  input logic             start_take,
  input logic             cmd_nop,
  input logic             cmd_wr,
  input logic             cmd_rd,
  input logic             cmd_prec,
  input logic             cmd_wra,
  input logic             cmd_rda,
  input logic             cmd_relax,
  input logic             cmd_other,
  input logic             x_prec,
  input logic             x_cal,
  input logic             x_calsam,
  input logic             x_relax,
  input logic             mask_vld
);
  logic any_out;
  assign any_out = cmd_nop | cmd_wr | cmd_rd | cmd_prec | cmd_wra | cmd_rda |
                   cmd_relax | cmd_other | x_prec | x_cal | x_calsam |
                   x_relax | mask_vld;

  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_nop, cmd_wr, cmd_rd, cmd_prec, cmd_wra, cmd_rda, cmd_other}));

  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |=> !any_out);

  assert_framed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(col_in[BUS_W-1] && attn, 4));

  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> !start_take);

  assert_other_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_other |-> !cmd_relax);

  assert_mask_no_xop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_vld |-> !(x_prec | x_cal | x_calsam | x_relax));

  assert_cal_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_cal && x_calsam));
endmodule

bind col_pkt_decoder col_pkt_decoder_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .col_in     (col_in),
  .attn       (attn),
  .start_take (start_take),
  .cmd_nop    (cmd_nop),
  .cmd_wr     (cmd_wr),
  .cmd_rd     (cmd_rd),
  .cmd_prec   (cmd_prec),
  .cmd_wra    (cmd_wra),
  .cmd_rda    (cmd_rda),
  .cmd_relax  (cmd_relax),
  .cmd_other  (cmd_other),
  .x_prec     (x_prec),
  .x_cal      (x_cal),
  .x_calsam   (x_calsam),
  .x_relax    (x_relax),
  .mask_vld   (mask_vld)
);

// File: tb/col_pkt_decoder_test.sv
module col_pkt_decoder_test;
  localparam int CLK_P = 10;
  localparam logic [4:0] MY_DEV = 5'h13;
  localparam logic [4:0] OTHER_DEV = 5'h0A;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n;
  logic [9:0] col_in;
  logic attn;
  logic [4:0] dev_id;
  logic cmd_nop, cmd_wr, cmd_rd, cmd_prec, cmd_wra, cmd_rda, cmd_relax, cmd_other;
  logic [4:0] cmd_bank;
  logic [6:0] cmd_col;
  logic x_prec, x_cal, x_calsam, x_relax;
  logic [4:0] x_bank;
  logic mask_vld;
  logic [7:0] mask_a, mask_b;

  col_pkt_decoder uut (
    .clk(clk), .rst_n(rst_n), .col_in(col_in), .attn(attn), .dev_id(dev_id),
    .cmd_nop(cmd_nop), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_prec(cmd_prec),
    .cmd_wra(cmd_wra), .cmd_rda(cmd_rda), .cmd_relax(cmd_relax),
    .cmd_other(cmd_other), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .x_prec(x_prec), .x_cal(x_cal), .x_calsam(x_calsam), .x_relax(x_relax),
    .x_bank(x_bank), .mask_vld(mask_vld), .mask_a(mask_a), .mask_b(mask_b)
  );

  logic [45:0] obs;
  assign obs = {cmd_nop, cmd_wr, cmd_rd, cmd_prec, cmd_wra, cmd_rda, cmd_relax,
                cmd_other, x_prec, x_cal, x_calsam, x_relax, mask_vld,
                mask_a, mask_b, cmd_bank, cmd_col, x_bank};

  logic [45:0] exp_q[$];
  int          when_q[$];
  string       tag_q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  // Expected outputs, worked out from the requirement text.
  function automatic logic [45:0] model(input logic [4:0] dv, input logic [4:0] bk,
      input logic [6:0] cl, input logic [3:0] op, input logic m,
      input logic [15:0] sd, input logic at);
    logic nop = 0, wr = 0, rd = 0, pr = 0, wra = 0, rda = 0, rlx = 0, oth = 0;
    logic xp = 0, xc = 0, xcs = 0, xr = 0, mv = 0;
    logic [7:0] ma = 0, mb = 0;
    logic [4:0] bo = 0, xb = 0, xo;
    logic [6:0] co = 0;
    if (at) begin
      bo = bk;
      co = cl;
      if (dv != MY_DEV) oth = 1;
      else begin
        rlx = op[3];
        if (op[2:0] == 3'd0) nop = 1;
        if (op[2:0] == 3'd1) wr  = 1;
        if (op[2:0] == 3'd3) rd  = 1;
        if (op[2:0] == 3'd4) pr  = 1;
        if (op[2:0] == 3'd5) wra = 1;
        if (op[2:0] == 3'd7) rda = 1;
      end
      if (m) begin
        mv = 1; ma = sd[15:8]; mb = sd[7:0];
      end else begin
        xb = sd[10:6];
        xo = sd[5:1];
        if (sd[15:11] == MY_DEV && xo[0] == 1'b0) begin
          xp = xo[4];
          xr = xo[1];
          if (xo[3:2] == 2'b10) xc = 1;
          if (xo[3:2] == 2'b11) xcs = 1;
        end
      end
    end
    return {nop, wr, rd, pr, wra, rda, rlx, oth, xp, xc, xcs, xr, mv, ma, mb, bo, co, xb};
  endfunction

  task automatic send(input logic [4:0] dv, input logic [4:0] bk, input logic [6:0] cl,
                      input logic [3:0] op, input logic m, input logic [15:0] sd,
                      input logic at, input string tag);
    logic [39:0] w;
    w = {1'b1, dv, bk, cl, op, 1'b0, m, sd};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 0) begin
        exp_q.push_back(model(dv, bk, cl, op, m, sd, at));
        when_q.push_back(cyc + 4);
        tag_q.push_back(tag);
      end
      attn   = at;
      col_in = w[39 - 10*i -: 10];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      col_in = '0;
      attn   = 1'b1;
    end
  endtask

  function automatic logic [15:0] xside(input logic [4:0] xd, input logic [4:0] xb,
                                        input logic [4:0] xo);
    return {xd, xb, xo, 1'b0};
  endfunction

  // Monitor: compares at the clock each result is due, flags strays.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_P/4);
      if (rst_n) begin
        if (when_q.size() > 0 && when_q[0] == cyc) begin
          logic [45:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          void'(when_q.pop_front());
          n_chk++;
          if (obs !== e) begin
            n_fail++;
            $display("FAIL %s: outputs %h expected %h", t, obs, e);
          end
        end else if (|obs[45:33]) begin
          n_chk++;
          n_fail++;
          $display("FAIL R1: stray strobes %b expected none", obs[45:33]);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; col_in = '0; attn = 1'b1; dev_id = MY_DEV;
    repeat (3) @(negedge clk);
    n_chk++;
    if (obs !== '0) begin n_fail++; $display("FAIL R12: in reset %h expected 0", obs); end
    // A start bit held during reset must not begin a packet.
    col_in = 10'h200;
    @(negedge clk);
    rst_n = 1'b1;
    col_in = '0;
    idle(3);
    n_chk++;
    if (obs !== '0) begin n_fail++; $display("FAIL R12: after reset %h expected 0", obs); end

    // R3 / R5: each command opcode with bank, column and masks (R2, R7).
    for (int i = 0; i < 8; i++) begin
      send(MY_DEV, 5'(2*i), 7'(9*i + 3), {1'b0, 3'(i)}, 1'b1, 16'hA55A ^ 16'(i),
           1'b1, (i == 2 || i == 6) ? "R5 reserved op" : "R3 op decode");
      idle(1);
    end
    send(MY_DEV, 5'h0E, 7'h55, 4'b0011, 1'b1, 16'h0180, 1'b1, "R2 field positions");
    idle(2);
    // R4: relax combined with actions and alone.
    send(MY_DEV, 5'h04, 7'h10, 4'b1001, 1'b1, 16'h00FF, 1'b1, "R4 write+relax");
    send(MY_DEV, 5'h06, 7'h11, 4'b1111, 1'b1, 16'hFF00, 1'b1, "R4 rda+relax");
    send(MY_DEV, 5'h08, 7'h12, 4'b1000, 0, xside(OTHER_DEV, 5'h3, 5'h10), 1'b1, "R4 nop+relax");
    send(MY_DEV, 5'h0A, 7'h13, 4'b1110, 0, 16'h0000, 1'b1, "R5 reserved+relax");
    idle(2);
    // R6: another device's command; R7 masks still shown.
    send(OTHER_DEV, 5'h02, 7'h20, 4'b1011, 1'b0, 16'h0000, 1'b1, "R6 other device");
    send(OTHER_DEV, 5'h04, 7'h21, 4'b0001, 1'b1, 16'h3CC3, 1'b1, "R7 masks other device");
    idle(1);
    // R8 / R9: extended operations.
    send(OTHER_DEV, 5'h02, 7'h30, 4'b0000, 1'b0, xside(MY_DEV, 5'h15, 5'b10000), 1'b1, "R8 xop own device");
    send(MY_DEV, 5'h02, 7'h31, 4'b0001, 1'b0, xside(OTHER_DEV, 5'h15, 5'b10000), 1'b1, "R8 xop other device");
    send(MY_DEV, 5'h02, 7'h32, 4'b0100, 1'b0, xside(MY_DEV, 5'h07, 5'b01000), 1'b1, "R9 calibrate");
    send(MY_DEV, 5'h02, 7'h33, 4'b0100, 1'b0, xside(MY_DEV, 5'h07, 5'b01100), 1'b1, "R9 cal+sample");
    send(MY_DEV, 5'h02, 7'h34, 4'b0100, 1'b0, xside(MY_DEV, 5'h07, 5'b00010), 1'b1, "R9 relax");
    send(MY_DEV, 5'h02, 7'h35, 4'b0100, 1'b0, xside(MY_DEV, 5'h07, 5'b10010), 1'b1, "R9 prec+relax");
    send(MY_DEV, 5'h02, 7'h36, 4'b0100, 1'b0, xside(MY_DEV, 5'h07, 5'b11110), 1'b1, "R9 all combined");
    send(MY_DEV, 5'h02, 7'h37, 4'b0010, 1'b0, xside(MY_DEV, 5'h07, 5'b10011), 1'b1, "R9 reserved xop");
    send(MY_DEV, 5'h02, 7'h38, 4'b0010, 1'b0, xside(MY_DEV, 5'h07, 5'b00001), 1'b1, "R9 reserved xop low");
    send(MY_DEV, 5'h02, 7'h39, 4'b0010, 1'b0, xside(MY_DEV, 5'h07, 5'b00000), 1'b1, "R9 xop nop");
    idle(2);
    // R10: packet while not in attention state.
    send(MY_DEV, 5'h1F, 7'h7F, 4'b0011, 1'b1, 16'hFFFF, 1'b0, "R10 attn low");
    idle(3);
    // R11: payload start-position bits set, back to back.
    send(MY_DEV, 5'h1F, 7'h40, 4'b0011, 1'b0, xside(MY_DEV, 5'h1E, 5'b10000), 1'b1, "R11 inner ones a");
    send(MY_DEV, 5'h1B, 7'h41, 4'b0111, 1'b0, xside(MY_DEV, 5'h1F, 5'b00010), 1'b1, "R11 inner ones b");
    send(OTHER_DEV, 5'h11, 7'h42, 4'b0010, 1'b1, 16'h0200, 1'b1, "R11 inner ones c");
    send(MY_DEV, 5'h01, 7'h43, 4'b0101, 1'b1, 16'h8001, 1'b1, "R11 back to back");
    idle(8);

    n_chk++;
    if (when_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d results missing expected 0", when_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule